// File: doc/BRIEF.md
# Four-channel programmable down-counter timer

The block is a register-mapped timer holding four identical down-counters that share one interrupt line. Software programs each channel with a start value, a reload value for the next wrap, and a control byte. The control byte selects enable, prescaler, width and the behaviour at zero. An enabled channel counts down once per prescaled tick. When it counts through zero it raises its raw status bit and continues according to its mode. In free-running mode it wraps to all ones. In periodic mode it takes the reload value. In one-shot mode it stops.

A shared group of four registers gathers the per-channel status. It holds the mask, the raw status, the masked status and the write-one-to-clear register, with bit n belonging to channel n. The single interrupt output is high while any unmasked status bit is set. The register port is a simple APB-style select/enable/write bus with zero wait states. Reads are combinational.

Top module: `quad_dcount_timer`

## Requirements
- R1: The shared registers sit at these byte offsets: mask at 0x00 (read/write, bits 3:0), raw status at 0x04 (read only), masked status at 0x08 (read only) and clear at 0x0C (write only, reads 0). Channel n (0..3) has its registers at 0x10+0x10·n: load +0x0, current value +0x4, control +0x8 (bits 7:0 readable) and reload +0xC. The load, control and reload registers read back what was written. Every other offset reads 0.
- R2: Control bit 7 enables the channel. An enabled channel decrements its value by one per tick. A disabled channel holds its value.
- R3: Control bits 3:2 select the tick rate: 00 ticks every clock, 01 every 16 clocks and 10 or 11 every 256 clocks. A control write restarts the prescaler, so the first decrement lands D clocks after the control write, where D is the divisor.
- R4: A tick that finds the value at 0 sets raw status bit n. With control bits 6 and 0 both clear (free-running), the value then becomes all ones for the selected width. A load write sets the value directly, and a full-width load of 0xFFFFFFFF is accepted.
- R5: With control bit 6 set and bit 0 clear (periodic), the wrap reloads the value from the reload register. A reload write alone leaves the current value unchanged.
- R6: With control bit 0 set (one-shot, which takes precedence over bit 6), the value stays at 0 after the wrap and no further events occur. A later load write restarts counting.
- R7: With control bit 1 clear the channel counts on its low 16 bits only. The value reads with bits 31:16 as zero, and the free-running wrap gives 0x0000FFFF. With bit 1 set, all 32 bits count.
- R8: Masked status is raw status AND mask. The interrupt output is high exactly when any masked bit is set.
- R9: Writing 1 to bit n of the clear register clears raw bit n. Zero bits in that write leave the raw bits alone, and writes to the raw status offset change nothing.
- R10: After reset every register, counter value and status reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register access select |
| penable | input | 1 | Access phase strobe; a write takes effect on the clock with psel, penable and pwrite high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded combinationally from paddr |
| irq | output | 1 | Combined interrupt, high while any unmasked status bit is set |

## Verification
The main sweep runs every channel through all three modes, divisors of 1 and 16, and both widths, each from the same small start value. The checks fall one prescaled tick before the first decrement, at that decrement, at zero, at the wrap and one tick after the wrap. This separates a prescaler that is off by one and an event raised a tick early from the three post-wrap values (all ones, reload value, held zero) and from leakage of status into other channels. The 16-bit runs load values with nonzero upper halves, so a missing width mask shows in the very first read. Further directed patterns cover the divide-by-256 code, a reload written mid-count, a full-width load, one-shot precedence over periodic, mask, clear and raw-write interplay, and unmapped reads.

// File: rtl/qdt_pkg.sv
`timescale 1ns/1ps
package qdt_pkg;
  // control byte field positions
  localparam int CR_EN      = 7;
  localparam int CR_PERIOD  = 6;
  localparam int CR_PRE_HI  = 3;
  localparam int CR_PRE_LO  = 2;
  localparam int CR_WIDE    = 1;
  localparam int CR_ONESHOT = 0;
  localparam int CR_W       = 8;

  // register word slots inside a channel window
  typedef enum logic [1:0] {
    SLOT_LOAD = 2'd0,
    SLOT_VAL  = 2'd1,
    SLOT_CTRL = 2'd2,
    SLOT_BG   = 2'd3
  } ch_slot_e;

  // shared window slots
  typedef enum logic [1:0] {
    SH_MASK  = 2'd0,
    SH_RAW   = 2'd1,
    SH_MSK   = 2'd2,
    SH_CLEAR = 2'd3
  } sh_slot_e;
endpackage

// File: rtl/qdt_prescaler.sv
`timescale 1ns/1ps
module qdt_prescaler #(
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int PW = HI_LOG;
  localparam logic [PW-1:0] LIM_MID = PW'((1 << MID_LOG) - 1);
  localparam logic [PW-1:0] LIM_HI  = PW'((1 << HI_LOG) - 1);

  logic [PW-1:0] pcnt_q, pcnt_n, limit;

  always_comb begin
    case (rate)
      2'b00:   limit = '0;
      2'b01:   limit = LIM_MID;
      default: limit = LIM_HI;
    endcase
  end

  assign tick = (pcnt_q == limit);

  always_comb begin
    if (restart || tick) pcnt_n = '0;
    else                 pcnt_n = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_n;
  end
endmodule

// File: rtl/qdt_channel.sv
`timescale 1ns/1ps
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int HALF    = 16,
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic            bg_we,
  input  logic            cr_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   val,
  output logic [DW-1:0]   ld_val,
  output logic [DW-1:0]   bg_val,
  output logic [CR_W-1:0] cr_val,
  output logic            evt,
  output logic            done
);
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-HALF){1'b0}}, {HALF{1'b1}}};

  logic [DW-1:0]   cnt_q, cnt_n, ld_q, ld_n, bg_q, bg_n, wmask, eff;
  logic [CR_W-1:0] cr_q, cr_n;
  logic            done_q, done_n, tick;

  qdt_prescaler #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) pre_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cr_we),
    .rate    (cr_q[CR_PRE_HI:CR_PRE_LO]),
    .tick    (tick)
  );

  assign wmask = cr_q[CR_WIDE] ? '1 : NARROW_MASK;
  assign eff   = cnt_q & wmask;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    ld_n   = ld_q;
    bg_n   = bg_q;
    cr_n   = cr_q;
    evt    = 1'b0;
    if (bg_we) bg_n = wdata;
    if (cr_we) begin
      cr_n   = wdata[CR_W-1:0];
      done_n = 1'b0;
    end
    if (ld_we) begin
      ld_n   = wdata;
      cnt_n  = wdata;
      done_n = 1'b0;
    end else if (cr_q[CR_EN] && !done_q && tick) begin
      if (eff == '0) begin
        evt = 1'b1;
        if (cr_q[CR_ONESHOT]) begin
          cnt_n  = '0;
          done_n = 1'b1;
        end else if (cr_q[CR_PERIOD]) begin
          cnt_n = bg_q & wmask;
        end else begin
          cnt_n = wmask;
        end
      end else begin
        cnt_n = eff - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      ld_q   <= '0;
      bg_q   <= '0;
      cr_q   <= '0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
      if (ld_we) ld_q <= ld_n;
      if (bg_we) bg_q <= bg_n;
      if (cr_we) cr_q <= cr_n;
    end
  end

  assign val    = eff;
  assign ld_val = ld_q;
  assign bg_val = bg_q;
  assign cr_val = cr_q;
  assign done   = done_q;
endmodule

// File: rtl/quad_dcount_timer.sv
`timescale 1ns/1ps
module quad_dcount_timer
  import qdt_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DW      = 32,
  parameter int AW      = 12,
  parameter int HALF    = 16,
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          irq
);
  localparam int WIN_W = AW - 4;

  logic                         wr_en, sh_hit;
  logic [1:0]                   slot;
  logic [WIN_W-1:0]             win;
  logic [NUM_CH-1:0]            ch_hit, ch_evt, ch_done, ch_wide;
  logic [NUM_CH-1:0][DW-1:0]    ch_val, ch_ld, ch_bg;
  logic [NUM_CH-1:0][CR_W-1:0]  ch_cr;
  logic [NUM_CH-1:0]            mask_q, mask_n, raw_q, raw_n, clr_bits;
  logic                         mask_we, clr_we;

  assign wr_en  = psel && penable && pwrite;
  assign win    = paddr[AW-1:4];
  assign slot   = paddr[3:2];
  assign sh_hit = (win == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      localparam logic [WIN_W-1:0] MY_WIN = WIN_W'(gi + 1);
      logic hit_we;
      assign ch_hit[gi] = (win == MY_WIN);
      assign hit_we     = wr_en && ch_hit[gi];
      qdt_channel #(
        .DW(DW), .HALF(HALF), .MID_LOG(MID_LOG), .HI_LOG(HI_LOG)
      ) ch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_we  (hit_we && (slot == SLOT_LOAD)),
        .bg_we  (hit_we && (slot == SLOT_BG)),
        .cr_we  (hit_we && (slot == SLOT_CTRL)),
        .wdata  (pwdata),
        .val    (ch_val[gi]),
        .ld_val (ch_ld[gi]),
        .bg_val (ch_bg[gi]),
        .cr_val (ch_cr[gi]),
        .evt    (ch_evt[gi]),
        .done   (ch_done[gi])
      );
      assign ch_wide[gi] = ch_cr[gi][CR_WIDE];
    end
  endgenerate

  assign mask_we  = wr_en && sh_hit && (slot == SH_MASK);
  assign clr_we   = wr_en && sh_hit && (slot == SH_CLEAR);
  assign clr_bits = clr_we ? pwdata[NUM_CH-1:0] : '0;

  always_comb begin
    mask_n = mask_we ? pwdata[NUM_CH-1:0] : mask_q;
    raw_n  = (raw_q & ~clr_bits) | ch_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (mask_we) mask_q <= mask_n;
      raw_q <= raw_n;
    end
  end

  assign irq = |(raw_q & mask_q);

  always_comb begin
    prdata = '0;
    if (sh_hit) begin
      case (slot)
        SH_MASK: prdata = {{(DW-NUM_CH){1'b0}}, mask_q};
        SH_RAW:  prdata = {{(DW-NUM_CH){1'b0}}, raw_q};
        SH_MSK:  prdata = {{(DW-NUM_CH){1'b0}}, raw_q & mask_q};
        default: prdata = '0;
      endcase
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (slot)
          SLOT_LOAD: prdata = ch_ld[i];
          SLOT_VAL:  prdata = ch_val[i];
          SLOT_CTRL: prdata = {{(DW-CR_W){1'b0}}, ch_cr[i]};
          default:   prdata = ch_bg[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/qdt_checker.sv
`timescale 1ns/1ps
module qdt_checker #(
  parameter int NUM_CH = 4,
  parameter int DW     = 32,
  parameter int AW     = 12,
  parameter int HALF   = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      psel,
  input logic                      penable,
  input logic                      pwrite,
  input logic [AW-1:0]             paddr,
  input logic [DW-1:0]             pwdata,
  input logic                      irq,
  input logic [NUM_CH-1:0]         raw_q,
  input logic [NUM_CH-1:0]         mask_q,
  input logic [NUM_CH-1:0]         ch_evt,
  input logic [NUM_CH-1:0]         ch_done,
  input logic [NUM_CH-1:0]         ch_wide,
  input logic [NUM_CH-1:0][DW-1:0] ch_val
);
  logic bus_wr, clr_wr;
  assign bus_wr = psel && penable && pwrite;
  assign clr_wr = bus_wr && (paddr == AW'(12'h00C));

  // R8: the line can only be high with some channel unmasked
  assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_chk
      logic ch_ctl_wr;
      assign ch_ctl_wr = bus_wr && (paddr[AW-1:4] == (AW-4)'(gi + 1)) &&
                         (paddr[3:2] == 2'd0 || paddr[3:2] == 2'd2);

      assert_evt_sets_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ch_evt[gi]) |-> raw_q[gi]);

      assert_raw_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_q[gi]) && !$past(clr_wr && pwdata[gi])) |-> raw_q[gi]);

      assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_wr && pwdata[gi] && !ch_evt[gi]) |-> !raw_q[gi]);

      assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ch_done[gi]) && !$past(ch_ctl_wr)) |-> (ch_val[gi] == $past(ch_val[gi])));

      assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_wide[gi] |-> (ch_val[gi][DW-1:HALF] == '0));
    end
  endgenerate
endmodule

bind quad_dcount_timer qdt_checker #(
  .NUM_CH(NUM_CH), .DW(DW), .AW(AW), .HALF(HALF)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .irq     (irq),
  .raw_q   (raw_q),
  .mask_q  (mask_q),
  .ch_evt  (ch_evt),
  .ch_done (ch_done),
  .ch_wide (ch_wide),
  .ch_val  (ch_val)
);

// File: tb/quad_dcount_timer_tb_top.sv
`timescale 1ns/1ps
module quad_dcount_timer_tb_top;
  logic        clk, rst_n, psel, penable, pwrite, irq;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  int          cyc, n_checks, n_fail;
  bit          finished;

  quad_dcount_timer dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b1; paddr = a;
    #1;
    d = prdata;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run_case(input int ch, input int m, input int p, input int w);
    int d, e;
    logic [11:0] base;
    logic [31:0] ones, ld, v, exp1, exp2;
    logic [7:0]  ctl;
    d    = (p == 0) ? 1 : 16;
    base = 12'(16 + 16 * ch);
    ones = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    ld   = w ? 32'h0000_0003 : 32'hABCD_0003;
    wr(base + 12'h8, 32'h0);
    wr(12'h00C, 32'hF);
    wr(base, ld);
    wr(base + 12'hC, 32'd5);
    ctl = 8'h80 | ((m == 1) ? 8'h40 : 8'h00) | ((m == 2) ? 8'h01 : 8'h00) |
          8'(p << 2) | 8'(w << 1);
    wr(base + 12'h8, {24'h0, ctl});
    e = cyc;
    if (d > 1) begin
      wait_to(e + d - 1); rd(base + 12'h4, v);
      chk("R3 hold before first tick", v, 32'd3);
    end
    wait_to(e + d); rd(base + 12'h4, v);
    chk(w ? "R2 first decrement" : "R7 narrow first decrement", v, 32'd2);
    wait_to(e + 3 * d); rd(base + 12'h4, v);
    chk("R2 reaches zero", v, 32'd0);
    rd(12'h004, v);
    chk("R4 no early event", v, 32'd0);
    wait_to(e + 4 * d); rd(12'h004, v);
    chk("R4 raw bit of own channel only", v, 32'(1 << ch));
    exp1 = (m == 0) ? ones : (m == 1) ? 32'd5 : 32'd0;
    exp2 = (m == 0) ? ones - 1 : (m == 1) ? 32'd4 : 32'd0;
    rd(base + 12'h4, v);
    chk((m == 0) ? "R4 free wrap" : (m == 1) ? "R5 periodic reload" : "R6 one-shot stop", v, exp1);
    wait_to(e + 5 * d); rd(base + 12'h4, v);
    chk((m == 0) ? "R4 free after wrap" : (m == 1) ? "R5 periodic after reload" : "R6 one-shot held", v, exp2);
    if (m == 2) begin
      rd(12'h004, v);
      chk("R6 no second event", v, 32'(1 << ch));
    end
  endtask

  initial begin
    logic [31:0] v;
    int e;
    n_checks = 0; n_fail = 0; finished = 1'b0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(12'h000, v); chk("R10 mask reset", v, 0);
    rd(12'h004, v); chk("R10 raw reset", v, 0);
    rd(12'h008, v); chk("R10 masked reset", v, 0);
    for (int c = 0; c < 4; c++) begin
      rd(12'(16 + 16 * c + 4), v); chk("R10 value reset", v, 0);
      rd(12'(16 + 16 * c + 8), v); chk("R10 control reset", v, 0);
    end
    chk("R10 irq reset", {31'h0, irq}, 0);

    // R1 readback and unmapped
    wr(12'h000, 32'hFFFF_FFFA); rd(12'h000, v); chk("R1 mask readback", v, 32'hA);
    wr(12'h030, 32'h1234_5678); rd(12'h030, v); chk("R1 load readback", v, 32'h1234_5678);
    wr(12'h04C, 32'hCAFE_0001); rd(12'h04C, v); chk("R1 reload readback", v, 32'hCAFE_0001);
    wr(12'h018, 32'hFFFF_FF4E); rd(12'h018, v); chk("R1 control readback", v, 32'h4E);
    rd(12'h050, v); chk("R1 unmapped 0x50", v, 0);
    rd(12'hFF0, v); chk("R1 unmapped 0xFF0", v, 0);
    rd(12'h00C, v); chk("R1 clear reads zero", v, 0);
    wr(12'h018, 32'h0);
    wr(12'h000, 32'h0);

    // R2 disabled hold
    wr(12'h010, 32'd9); wr(12'h018, 32'h02);
    repeat (20) @(negedge clk);
    rd(12'h014, v); chk("R2 disabled holds", v, 32'd9);

    // main sweep
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 3; m++)
        for (int p = 0; p < 2; p++)
          for (int w = 0; w < 2; w++)
            run_case(c, m, p, w);
    for (int c = 0; c < 4; c++) wr(12'(16 + 16 * c + 8), 32'h0);
    wr(12'h00C, 32'hF);

    // R3 divide by 256, codes 10 and 11
    wr(12'h020, 32'd1); wr(12'h028, 32'h8A); e = cyc;
    wait_to(e + 255); rd(12'h024, v); chk("R3 div256 hold", v, 32'd1);
    wait_to(e + 256); rd(12'h024, v); chk("R3 div256 tick", v, 32'd0);
    wait_to(e + 512); rd(12'h004, v); chk("R3 div256 event", v, 32'h2);
    wr(12'h020, 32'd4); wr(12'h028, 32'h8E); e = cyc;
    wait_to(e + 255); rd(12'h024, v); chk("R3 code 11 hold", v, 32'd4);
    wait_to(e + 256); rd(12'h024, v); chk("R3 code 11 tick", v, 32'd3);
    wr(12'h028, 32'h0); wr(12'h00C, 32'hF);

    // R5 reload written mid-count
    wr(12'h030, 32'd3); wr(12'h03C, 32'd5); wr(12'h038, 32'hC6); e = cyc;
    wr(12'h03C, 32'd7);
    wait_to(e + 10); rd(12'h034, v); chk("R5 reload write no immediate effect", v, 32'd3);
    wait_to(e + 64); rd(12'h034, v); chk("R5 reload uses new value", v, 32'd7);
    wait_to(e + 80); rd(12'h034, v); chk("R5 counts from new value", v, 32'd6);
    wr(12'h038, 32'h0); wr(12'h00C, 32'hF);

    // R4 full-width load
    wr(12'h040, 32'hFFFF_FFFF); wr(12'h048, 32'h82); e = cyc;
    wait_to(e + 1); rd(12'h044, v); chk("R4 max load decrement", v, 32'hFFFF_FFFE);
    wr(12'h048, 32'h0);

    // R6 one-shot precedence and restart
    wr(12'h00C, 32'hF);
    wr(12'h010, 32'd1); wr(12'h01C, 32'd9); wr(12'h018, 32'hC3); e = cyc;
    wait_to(e + 2); rd(12'h014, v); chk("R6 precedence over periodic", v, 32'd0);
    wait_to(e + 6); rd(12'h014, v); chk("R6 stays at zero", v, 32'd0);
    wr(12'h010, 32'd2); e = cyc;
    wait_to(e + 1); rd(12'h014, v); chk("R6 load restarts", v, 32'd1);
    wr(12'h018, 32'h0);

    // R8 mask and irq, R9 clear
    rd(12'h004, v); chk("R8 raw pending", v, 32'h1);
    rd(12'h008, v); chk("R8 masked with mask 0", v, 32'h0);
    chk("R8 irq low when masked", {31'h0, irq}, 0);
    wr(12'h000, 32'h1);
    rd(12'h008, v); chk("R8 masked status", v, 32'h1);
    chk("R8 irq high", {31'h0, irq}, 1);
    wr(12'h000, 32'h2);
    chk("R8 irq low other mask", {31'h0, irq}, 0);
    wr(12'h000, 32'h1);
    wr(12'h004, 32'h0); rd(12'h004, v); chk("R9 raw write ignored", v, 32'h1);
    wr(12'h00C, 32'hE); rd(12'h004, v); chk("R9 zero bits keep raw", v, 32'h1);
    wr(12'h00C, 32'h1); rd(12'h004, v); chk("R9 clear bit", v, 32'h0);
    chk("R9 irq low after clear", {31'h0, irq}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired R10 got=%h exp=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule